// File: doc/BRIEF.md
# Fractional Frame-Length Dither Sequencer

This block sits next to a display vertical timing generator and hands it, once per frame, a vertical total and a matching vertical front porch. When the ideal line count for a target refresh rate is not a whole number, the sequencer alternates between a base total and the base plus one. The choice follows a programmable bit pattern, so the average over many frames lands on the fractional value.

Software fills a pending pattern buffer one byte at a time. An apply strobe captures the base total and the pattern length. The pending set becomes active at the next frame-start event, so no frame ever runs on a mix of old and new settings. On every accepted frame start the block registers the new total and porch, and pulses an update flag for the timing generator.

Top module: `fdith_seq`

## Requirements
- R1: An accepted frame loads `vtotal_o` with the active base when the selected pattern bit is 0, and with base + 1 when it is 1.
- R2: The selected bit index is the frame count modulo the active length. The counter goes back to 0 after index length-1.
- R3: Pattern bits are ordered MSB-first. Index i selects bit 7-(i mod 8) of byte i/8, and byte a is the one written with `pat_addr` = a.
- R4: An active length of 0 selects the base total on every frame.
- R5: On each update, `vfp_o` = (`nom_vsync_start` - `nom_vdisplay`) + (`vtotal_o` - `nom_vtotal`), modulo 2^VT_W.
- R6: After `cfg_apply`, the next `frame_start` promotes the pending set. That frame uses index 0, and the frames after it use indices 1, 2 and so on.
- R7: Pattern writes, and `cfg_base`/`cfg_len` values captured at an apply, have no effect on the outputs until the promotion.
- R8: The outputs change only on the clock edge that samples `frame_start` high with `mode_en` high. A frame start with `mode_en` low leaves the outputs unchanged.
- R9: A computed total of 0 is rejected. The outputs are held, `timing_upd_o` stays low and the counter does not advance.
- R10: A `cfg_len` larger than PAT_BITS is clamped to PAT_BITS.
- R11: `timing_upd_o` is high for exactly the cycle after each accepted frame start.
- R12: After reset, `vtotal_o` and `vfp_o` are 0, `timing_upd_o` is low and no pattern is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_we | input | 1 | Write one byte of the pending pattern |
| pat_addr | input | $clog2(PAT_BITS/8) | Pending pattern byte address |
| pat_byte | input | 8 | Pending pattern byte data |
| cfg_base | input | VT_W | Base vertical total, captured at apply |
| cfg_len | input | $clog2(PAT_BITS+1) | Pattern length in bits, captured at apply |
| cfg_apply | input | 1 | Arm the pending set for the next frame start |
| mode_en | input | 1 | Fractional mode active |
| frame_start | input | 1 | One-cycle frame boundary event |
| nom_vtotal | input | VT_W | Nominal vertical total of the mode |
| nom_vsync_start | input | VT_W | Nominal vsync start line |
| nom_vdisplay | input | VT_W | Nominal active line count |
| vtotal_o | output | VT_W | Vertical total for the current frame |
| vfp_o | output | VT_W | Adjusted vertical front porch |
| timing_upd_o | output | 1 | New timing loaded this cycle |

## Verification
The bench builds the block with its defaults: 16-bit line counts and a 128-bit pattern of 16 bytes. At that size one run can walk a full 128-frame pattern cycle, which exercises both the clamp of an oversized length and the wrap at the last index. It also lets a 12-bit pattern cross from one byte into the next. The 16-bit totals are wide enough to use realistic line counts of 750 to 1200 in the porch arithmetic.

// File: rtl/fdith_pkg.sv
package fdith_pkg;

    localparam int DEF_VT_W     = 16;
    localparam int DEF_PAT_BITS = 128;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_STEP   = 2'd1,
        EV_SWITCH = 2'd2
    } fd_event_e;

    // position following pos in a ring of len entries; len 0 pins to 0
    function automatic int next_pos(input int pos, input int len);
        if (len == 0)        return 0;
        if (pos + 1 >= len)  return 0;
        return pos + 1;
    endfunction

endpackage

// File: rtl/fdith_frame_ctr.sv
module fdith_frame_ctr
    import fdith_pkg::*;
#(
    parameter  int PAT_BITS = DEF_PAT_BITS,
    localparam int IDX_W    = $clog2(PAT_BITS),
    localparam int LEN_W    = $clog2(PAT_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] pos
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            // frame that switches consumes index 0
            s_d.cnt = adv ? IDX_W'(next_pos(0, int'(len))) : '0;
        end else if (adv) begin
            s_d.cnt = IDX_W'(next_pos(int'(s_q.cnt), int'(len)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos = s_q.cnt;

endmodule

// File: rtl/fdith_patbuf.sv
module fdith_patbuf
    import fdith_pkg::*;
#(
    parameter  int PAT_BITS  = DEF_PAT_BITS,
    localparam int PAT_BYTES = PAT_BITS / 8,
    localparam int BYTE_AW   = $clog2(PAT_BYTES),
    localparam int IDX_W     = $clog2(PAT_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_AW-1:0] wr_addr,
    input  logic [7:0]         wr_byte,
    input  logic               promote,
    input  logic [IDX_W-1:0]   pos,
    output logic               bit_o
);

    typedef struct packed {
        logic [PAT_BYTES-1:0][7:0] pend;
        logic [PAT_BYTES-1:0][7:0] act;
    } buf_t;

    buf_t s_d, s_q;
    logic [PAT_BITS-1:0] act_flat;

    always_comb begin
        s_d = s_q;
        if (promote) s_d.act = s_q.pend;
        if (wr_en)   s_d.pend[wr_addr] = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // flat index i maps to the MSB-first bit of its byte
    for (genvar i = 0; i < PAT_BITS; i++) begin : g_flat
        assign act_flat[i] = s_q.act[i / 8][7 - (i % 8)];
    end

    // a promoting frame reads index 0 of the incoming pattern
    assign bit_o = promote ? s_q.pend[0][7] : act_flat[pos];

endmodule

// File: rtl/fdith_porch.sv
module fdith_porch
    import fdith_pkg::*;
#(
    parameter int VT_W = DEF_VT_W
) (
    input  logic [VT_W-1:0] vtot,
    input  logic [VT_W-1:0] nom_vtotal,
    input  logic [VT_W-1:0] nom_vsync_start,
    input  logic [VT_W-1:0] nom_vdisplay,
    output logic [VT_W-1:0] vfp
);

    logic [VT_W-1:0] base_fp;
    logic [VT_W-1:0] delta;

    always_comb begin
        base_fp = nom_vsync_start - nom_vdisplay;
        delta   = vtot - nom_vtotal;
        vfp     = base_fp + delta;
    end

endmodule

// File: rtl/fdith_seq.sv
module fdith_seq
    import fdith_pkg::*;
#(
    parameter  int VT_W      = DEF_VT_W,
    parameter  int PAT_BITS  = DEF_PAT_BITS,
    localparam int LEN_W     = $clog2(PAT_BITS + 1),
    localparam int IDX_W     = $clog2(PAT_BITS),
    localparam int BYTE_AW   = $clog2(PAT_BITS / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pat_we,
    input  logic [BYTE_AW-1:0] pat_addr,
    input  logic [7:0]         pat_byte,
    input  logic [VT_W-1:0]    cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_apply,
    input  logic               mode_en,
    input  logic               frame_start,
    input  logic [VT_W-1:0]    nom_vtotal,
    input  logic [VT_W-1:0]    nom_vsync_start,
    input  logic [VT_W-1:0]    nom_vdisplay,
    output logic [VT_W-1:0]    vtotal_o,
    output logic [VT_W-1:0]    vfp_o,
    output logic               timing_upd_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PAT_BITS);

    typedef struct packed {
        logic             arm;
        logic [VT_W-1:0]  pbase;
        logic [LEN_W-1:0] plen;
        logic [VT_W-1:0]  base;
        logic [LEN_W-1:0] len;
        logic [VT_W-1:0]  vtot;
        logic [VT_W-1:0]  vfp;
        logic             upd;
    } seq_t;

    seq_t s_d, s_q;

    fd_event_e        ev;
    logic             sw;
    logic [VT_W-1:0]  eff_base;
    logic [LEN_W-1:0] eff_len;
    logic [IDX_W-1:0] ctr_pos;
    logic [IDX_W-1:0] use_pos;
    logic             pat_bit;
    logic [VT_W-1:0]  cand;
    logic             adv;
    logic [VT_W-1:0]  cand_vfp;

    always_comb begin
        sw       = frame_start & s_q.arm;
        eff_base = sw ? s_q.pbase : s_q.base;
        eff_len  = sw ? s_q.plen  : s_q.len;
        use_pos  = sw ? '0 : ctr_pos;
        cand     = eff_base + VT_W'((eff_len != '0) & pat_bit);
        adv      = frame_start & mode_en & (cand != '0);
        if (sw)       ev = EV_SWITCH;
        else if (adv) ev = EV_STEP;
        else          ev = EV_NONE;
    end

    always_comb begin
        s_d     = s_q;
        s_d.arm = (s_q.arm & ~frame_start) | cfg_apply;
        if (cfg_apply) begin
            s_d.pbase = cfg_base;
            s_d.plen  = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
        end
        if (ev == EV_SWITCH) begin
            s_d.base = s_q.pbase;
            s_d.len  = s_q.plen;
        end
        s_d.upd = adv;
        if (adv) begin
            s_d.vtot = cand;
            s_d.vfp  = cand_vfp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    fdith_frame_ctr #(.PAT_BITS(PAT_BITS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ev == EV_SWITCH),
        .adv     (adv),
        .len     (eff_len),
        .pos     (ctr_pos)
    );

    fdith_patbuf #(.PAT_BITS(PAT_BITS)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pat_we),
        .wr_addr (pat_addr),
        .wr_byte (pat_byte),
        .promote (sw),
        .pos     (use_pos),
        .bit_o   (pat_bit)
    );

    fdith_porch #(.VT_W(VT_W)) u_porch (
        .vtot            (cand),
        .nom_vtotal      (nom_vtotal),
        .nom_vsync_start (nom_vsync_start),
        .nom_vdisplay    (nom_vdisplay),
        .vfp             (cand_vfp)
    );

    assign vtotal_o     = s_q.vtot;
    assign vfp_o        = s_q.vfp;
    assign timing_upd_o = s_q.upd;

endmodule

// File: rtl/fdith_seq_chk.sv
module fdith_seq_chk #(
    parameter int VT_W  = 16,
    parameter int LEN_W = 8,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             mode_en,
    input logic [VT_W-1:0]  nom_vtotal,
    input logic [VT_W-1:0]  nom_vsync_start,
    input logic [VT_W-1:0]  nom_vdisplay,
    input logic [VT_W-1:0]  vtotal_o,
    input logic [VT_W-1:0]  vfp_o,
    input logic             timing_upd_o,
    input logic [VT_W-1:0]  act_base,
    input logic [LEN_W-1:0] act_len,
    input logic [IDX_W-1:0] pos
);

    localparam logic [VT_W-1:0] ONE = VT_W'(1);

    a_r1_base_or_next: assert property (@(posedge clk) disable iff (!rst_n)
        timing_upd_o |-> (vtotal_o == act_base) || (vtotal_o == act_base + ONE));

    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (act_len != '0) |-> (int'(pos) < int'(act_len)));

    a_r5_porch: assert property (@(posedge clk) disable iff (!rst_n)
        timing_upd_o |-> vfp_o == VT_W'(($past(nom_vsync_start) - $past(nom_vdisplay))
                                       + (vtotal_o - $past(nom_vtotal))));

    a_r8_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        timing_upd_o |-> $past(frame_start && mode_en));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_upd_o |-> $stable(vtotal_o) && $stable(vfp_o));

    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        timing_upd_o |-> vtotal_o != '0);

endmodule

bind fdith_seq fdith_seq_chk #(.VT_W(VT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .mode_en         (mode_en),
    .nom_vtotal      (nom_vtotal),
    .nom_vsync_start (nom_vsync_start),
    .nom_vdisplay    (nom_vdisplay),
    .vtotal_o        (vtotal_o),
    .vfp_o           (vfp_o),
    .timing_upd_o    (timing_upd_o),
    .act_base        (s_q.base),
    .act_len         (s_q.len),
    .pos             (ctr_pos)
);

// File: tb/fdith_seq_bench.sv
module fdith_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 1'b0;
    logic [3:0]  pat_addr = '0;
    logic [7:0]  pat_byte = '0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0;
    logic        cfg_apply = 1'b0;
    logic        mode_en = 1'b1;
    logic        frame_start = 1'b0;
    logic [15:0] nom_vtotal = 16'd750;
    logic [15:0] nom_vsync_start = 16'd725;
    logic [15:0] nom_vdisplay = 16'd720;
    logic [15:0] vtotal_o;
    logic [15:0] vfp_o;
    logic        timing_upd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] shadow [16];

    // pattern 0x3C over 8 bits, base 750, twelve frames
    localparam logic [15:0] TBL_A [12] = '{
        16'd750, 16'd750, 16'd751, 16'd751, 16'd751, 16'd751,
        16'd750, 16'd750, 16'd750, 16'd750, 16'd751, 16'd751
    };

    always #5ns clk = ~clk;

    fdith_seq u_fdith_seq (
        .clk (clk), .rst_n (rst_n),
        .pat_we (pat_we), .pat_addr (pat_addr), .pat_byte (pat_byte),
        .cfg_base (cfg_base), .cfg_len (cfg_len), .cfg_apply (cfg_apply),
        .mode_en (mode_en), .frame_start (frame_start),
        .nom_vtotal (nom_vtotal), .nom_vsync_start (nom_vsync_start),
        .nom_vdisplay (nom_vdisplay),
        .vtotal_o (vtotal_o), .vfp_o (vfp_o), .timing_upd_o (timing_upd_o)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] b);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = 4'(a); pat_byte = b;
        shadow[a] = b;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic apply(input logic [15:0] b, input logic [7:0] l);
        @(negedge clk);
        cfg_apply = 1'b1; cfg_base = b; cfg_len = l;
        @(negedge clk);
        cfg_apply = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    // accepted frame: total, porch (nominal porch 5, nominal total 750) and pulse
    task automatic frame_chk(input string req, input logic [15:0] exp_vt);
        frame();
        chk(req, vtotal_o, exp_vt, "vtotal");
        chk("R5", vfp_o, 16'(exp_vt + 16'd5 - 16'd750), "vfp");
        chk("R11", timing_upd_o, 1, "upd");
    endtask

    function automatic logic pat_bit(input int i);
        return shadow[i / 8][7 - (i % 8)];
    endfunction

    initial begin
        logic [15:0] held_vt;
        logic [15:0] held_fp;
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", vtotal_o, 0, "vtotal");
        chk("R12", vfp_o, 0, "vfp");
        chk("R12", timing_upd_o, 0, "upd");
        rst_n = 1'b1;
        frame();
        chk("R12", timing_upd_o, 0, "upd with no pattern");

        // R1 R2 R6: table walk, wraps after 8 frames
        wr(0, 8'h3C);
        apply(16'd750, 8'd8);
        for (int i = 0; i < 12; i++) frame_chk("R2", TBL_A[i]);
        @(negedge clk);
        chk("R11", timing_upd_o, 0, "upd falls");

        // R7: pending write and unapplied base do not reach the outputs (index 4 -> 1)
        cfg_base = 16'd900;
        wr(0, 8'h00);
        frame_chk("R7", 16'd751);

        // R8: frame start with mode off is ignored
        mode_en = 1'b0;
        frame();
        chk("R8", vtotal_o, 751, "vtotal held");
        chk("R8", timing_upd_o, 0, "no upd");
        mode_en = 1'b1;

        // R6: apply promotes at next frame start, index 0 first
        apply(16'd900, 8'd8);
        chk("R6", vtotal_o, 751, "before promotion");
        frame_chk("R6", 16'd900);

        // R3: 12-bit pattern across two bytes, MSB first
        wr(0, 8'h0F);
        wr(1, 8'hA0);
        apply(16'd1125, 8'd12);
        for (int i = 0; i < 14; i++)
            frame_chk("R3", 16'd1125 + 16'(pat_bit(i % 12)));

        // R4: zero length keeps base
        apply(16'd1200, 8'd0);
        for (int i = 0; i < 3; i++) frame_chk("R4", 16'd1200);

        // R9: zero total rejected
        held_vt = vtotal_o;
        held_fp = vfp_o;
        wr(0, 8'h00);
        apply(16'd0, 8'd8);
        frame();
        chk("R9", vtotal_o, held_vt, "vtotal held");
        chk("R9", vfp_o, held_fp, "vfp held");
        chk("R9", timing_upd_o, 0, "no upd");

        // R10: length 200 clamps to 128
        wr(0, 8'h80);
        wr(1, 8'h00);
        apply(16'd1000, 8'd200);
        for (int i = 0; i < 129; i++)
            frame_chk("R10", (i % 128 == 0) ? 16'd1001 : 16'd1000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule